// File: doc/BRIEF.md
# Programmable Edge Delay Timer

This block delays transitions of a single-bit input by a programmable number of master clock periods. The delay is a fixed base count multiplied by a power-of-eight ratio. A four-bit divider code selects both the ratio and a polarity flag. A clock-enable input stands in for the master oscillator. While it is low, a delay can still begin, but its count is frozen until the enable returns.

There are two modes. In single-edge mode, one input edge is delayed and the opposite edge passes through with only the synchronizer latency. A polarity flag of 0 delays rising edges and a flag of 1 delays falling edges. In both-edge mode, every transition is delayed by the same time, and a polarity flag of 1 inverts the output.

A control state machine has two states. `ST_IDLE` tracks the accepted level. `ST_TIMING` counts toward the programmed limit. The transitions are:

- **pass**: an undelayed edge is taken at once and the machine stays in `ST_IDLE`.
- **start**: a delayed edge is seen and the machine moves from `ST_IDLE` to `ST_TIMING`.
- **cancel**: the input returns to the accepted level and the machine moves from `ST_TIMING` to `ST_IDLE`.
- **expire**: the last counted period completes, the new level is accepted, and the machine moves from `ST_TIMING` to `ST_IDLE`.

Top module: `edge_delay_timer`

## Requirements
- R1: During and right after a reset, the output equals `both_mode & div_code[3]`, that is, the idle level for the configured mode and polarity.
- R2: In single-edge mode with polarity 0 (`div_code[3]`=0), a rising input edge reaches the output LIMIT clock cycles later than an undelayed edge, and a falling edge is undelayed.
- R3: In single-edge mode with polarity 1, a falling input edge is delayed by LIMIT cycles and a rising edge is undelayed.
- R4: In both-edge mode, rising and falling input edges are each delayed by the same LIMIT cycles.
- R5: In both-edge mode, polarity 1 presents the inverted delayed level on the output, and polarity 0 presents it unchanged.
- R6: The polarity flag is `div_code[3]`. The exponent E is `div_code[2:0]` when the flag is 0 and `7 - div_code[2:0]` when it is 1. E is clamped to DIV_LEVELS-1, and LIMIT = BASE_CNT * 8^E. For example, code 14 gives polarity 1 with a ratio of 8.
- R7: Each clock cycle with `osc_en` low during a pending delay lengthens that delay by one cycle. A delay may start while `osc_en` is low, and the count never exceeds LIMIT-1.
- R8: In single-edge mode, if the undelayed edge arrives while a delay is pending, the pending edge is discarded and the output does not change. A later delayed edge is timed in full.
- R9: In both-edge mode, an input pulse lasting at most LIMIT cycles never reaches the output. A pulse of W > LIMIT cycles appears with width W, LIMIT cycles late.
- R10: Changes on `both_mode` and `div_code` while a delay is pending do not alter that delay. They take effect once the block is idle.
- R11: The input passes through a two-flop synchronizer, so an undelayed edge appears on the output after the third rising clock edge that follows the input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Input whose transitions are delayed |
| both_mode | input | 1 | 1 selects both-edge mode, 0 selects single-edge mode |
| div_code | input | 4 | Divider code: polarity flag in bit 3, ratio exponent in bits 2:0 |
| osc_en | input | 1 | Master clock running; counting pauses while low |
| dout | output | 1 | Delayed output |

## Verification
The bench builds the block with BASE_CNT = 2 and DIV_LEVELS = 4, giving limits of 2, 16, 128 and 1024 cycles. At these sizes, every one of the sixteen divider codes can be swept in both modes with both edge directions, including the clamped exponents. Each edge latency is compared with a value computed from the code.

The small limits also make the exact pulse-width boundary for suppression cheap to reach. The same holds for frozen counts, cancellation, and mid-delay configuration changes, each at a precise cycle offset.

// File: rtl/edt_pkg.sv
package edt_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_TIMING = 1'b1
    } edt_state_e;

    typedef struct packed {
        logic       both;
        logic       pol;
        logic [2:0] expo;
    } edt_cfg_t;

    // Polarity 1 codes count the exponent downward from 7.
    function automatic logic [2:0] edt_expo_of(input logic [3:0] code);
        return code[3] ? ~code[2:0] : code[2:0];
    endfunction

    function automatic edt_cfg_t edt_cfg_of(input logic both, input logic [3:0] code);
        edt_cfg_t c;
        c.both = both;
        c.pol  = code[3];
        c.expo = edt_expo_of(code);
        return c;
    endfunction

endpackage

// File: rtl/edt_sync.sv
module edt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/edt_div_decode.sv
module edt_div_decode
    import edt_pkg::*;
#(
    parameter int BASE_CNT   = 16,
    parameter int DIV_LEVELS = 8,
    parameter int CNT_W      = 26
) (
    input  edt_cfg_t           cfg,
    output logic [CNT_W-1:0]   limit
);
    localparam int MAX_EXP = DIV_LEVELS - 1;

    logic [CNT_W-1:0] lim_tab [8];

    generate
        for (genvar g = 0; g < 8; g++) begin : g_lim
            localparam int EFF = (g < MAX_EXP) ? g : MAX_EXP;
            assign lim_tab[g] = CNT_W'(BASE_CNT) << (3 * EFF);
        end
    endgenerate

    always_comb begin
        limit = lim_tab[cfg.expo];
    end
endmodule

// File: rtl/edt_counter.sv
module edt_counter #(
    parameter int CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (en)    cnt <= cnt + CNT_W'(1);
    end

    assign last = (cnt == limit - CNT_W'(1));
endmodule

// File: rtl/edge_delay_timer.sv
module edge_delay_timer
    import edt_pkg::*;
#(
    parameter int BASE_CNT    = 16,
    parameter int DIV_LEVELS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  logic       both_mode,
    input  logic [3:0] div_code,
    input  logic       osc_en,
    output logic       dout
);
    localparam int CNT_W = $clog2(BASE_CNT + 1) + 3 * (DIV_LEVELS - 1);

    edt_state_e       st_q, st_d;
    logic             held_q, held_d;
    edt_cfg_t         cfg_q, cfg_live;
    logic             din_s;
    logic             cnt_clr, cnt_en, cnt_last;
    logic             delayed_edge;
    logic [CNT_W-1:0] limit, cnt;

    assign cfg_live = edt_cfg_of(both_mode, div_code);

    edt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (din),
        .q   (din_s)
    );

    edt_div_decode #(
        .BASE_CNT   (BASE_CNT),
        .DIV_LEVELS (DIV_LEVELS),
        .CNT_W      (CNT_W)
    ) dec_i (
        .cfg   (cfg_q),
        .limit (limit)
    );

    edt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .limit (limit),
        .cnt   (cnt),
        .last  (cnt_last)
    );

    // Both-edge mode delays every edge; single-edge mode delays the edge
    // whose new level is the inverse of the polarity flag.
    assign delayed_edge = cfg_q.both | (din_s == ~cfg_q.pol);

    always_comb begin
        st_d    = st_q;
        held_d  = held_q;
        cnt_clr = 1'b0;
        cnt_en  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (din_s != held_q) begin
                    if (delayed_edge) begin
                        st_d    = ST_TIMING;   // start
                        cnt_clr = 1'b1;
                    end else begin
                        held_d  = din_s;       // pass
                    end
                end
            end
            ST_TIMING: begin
                if (din_s == held_q) begin
                    st_d = ST_IDLE;            // cancel
                end else if (osc_en) begin
                    if (cnt_last) begin
                        held_d = din_s;        // expire
                        st_d   = ST_IDLE;
                    end else begin
                        cnt_en = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            held_q <= 1'b0;
            cfg_q  <= cfg_live;
        end else begin
            st_q   <= st_d;
            held_q <= held_d;
            if (st_d == ST_IDLE) cfg_q <= cfg_live;
        end
    end

    always_comb begin
        dout = held_q ^ (cfg_q.both & cfg_q.pol);
    end
endmodule

// File: rtl/edt_chk.sv
module edt_chk
    import edt_pkg::*;
#(
    parameter int CNT_W = 26
) (
    input logic             clk,
    input logic             rst,
    input logic             osc_en,
    input logic             both_mode,
    input logic [3:0]       div_code,
    input logic             dout,
    input edt_state_e       st,
    input logic             held,
    input edt_cfg_t         cfg,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] limit
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dout == ($past(both_mode) & $past(div_code[3]))));

    // R2
    rise_after_count_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(held) && !$past(cfg.both) && !$past(cfg.pol)) |-> ($past(st) == ST_TIMING));

    // R3
    fall_after_count_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(held) && !$past(cfg.both) && $past(cfg.pol)) |-> ($past(st) == ST_TIMING));

    // R4
    both_after_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(held) && $past(cfg.both)) |-> ($past(st) == ST_TIMING && $past(osc_en)));

    // R7
    freeze_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TIMING && !osc_en) |=> $stable(cnt));

    // R7
    no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TIMING) |-> (cnt < limit));

    // R9
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TIMING && $past(st) == ST_TIMING) |-> $stable(dout));

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TIMING && $past(st) == ST_TIMING) |-> $stable(cfg));
endmodule

bind edge_delay_timer edt_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .osc_en    (osc_en),
    .both_mode (both_mode),
    .div_code  (div_code),
    .dout      (dout),
    .st        (st_q),
    .held      (held_q),
    .cfg       (cfg_q),
    .cnt       (cnt),
    .limit     (limit)
);

// File: tb/edge_delay_timer_tb_top.sv
module edge_delay_timer_tb_top;
    localparam int BASE   = 2;
    localparam int LEVELS = 4;
    localparam int LAT    = 3;   // negedges from drive to an undelayed output change

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic       both_mode = 1'b0;
    logic [3:0] div_code = 4'd0;
    logic       osc_en = 1'b1;
    logic       dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    edge_delay_timer #(.BASE_CNT(BASE), .DIV_LEVELS(LEVELS)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .both_mode (both_mode),
        .div_code  (div_code),
        .osc_en    (osc_en),
        .dout      (dout)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lim_of(input logic [3:0] code);
        int e = code[3] ? 7 - int'(code[2:0]) : int'(code[2:0]);
        if (e > LEVELS - 1) e = LEVELS - 1;
        return BASE * (8 ** e);
    endfunction

    task automatic do_reset(input logic both, input logic [3:0] code);
        @(negedge clk);
        rst = 1'b1; din = 1'b0; osc_en = 1'b1;
        both_mode = both; div_code = code;
        repeat (3) @(negedge clk);
        chk("R1 reset level", int'(dout), int'(both & code[3]));
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", int'(dout), int'(both & code[3]));
    endtask

    task automatic measure(input logic v, input logic lvl, output int n);
        @(negedge clk);
        din = v;
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            n++;
            if (dout == lvl) break;
        end
    endtask

    // Pulse of W cycles; reports first negedge with dout != idle and width.
    task automatic pulse(input int w, input int obs, input logic idle,
                         output int first, output int width);
        @(negedge clk);
        din = 1'b1;
        first = 0; width = 0;
        for (int n = 1; n <= obs; n++) begin
            @(negedge clk);
            if (dout != idle) begin
                if (first == 0) first = n;
                width++;
            end
            if (n == w) din = 1'b0;
        end
    endtask

    initial begin
        int n, f, w, lim, expd;
        logic pol, inv;
        // Sweep all codes in both modes: R2 R3 R4 R5 R6 R11
        for (int b = 0; b < 2; b++) begin
            for (int c = 0; c < 16; c++) begin
                do_reset(b[0], c[3:0]);
                pol = c[3]; inv = b[0] & pol;
                lim = lim_of(c[3:0]);
                expd = (b == 1 || !pol) ? LAT + lim : LAT;
                measure(1'b1, 1'b1 ^ inv, n);
                chk(b ? "R4 R5 R6 rise" : (pol ? "R3 R11 rise" : "R2 R6 rise"), n, expd);
                chk("R5 level high", int'(dout), int'(1'b1 ^ inv));
                repeat (2) @(negedge clk);
                expd = (b == 1 || pol) ? LAT + lim : LAT;
                measure(1'b0, inv, n);
                chk(b ? "R4 R5 R6 fall" : (pol ? "R3 R6 fall" : "R2 R11 fall"), n, expd);
                chk("R5 level low", int'(dout), int'(inv));
                repeat (2) @(negedge clk);
            end
        end
        // R6: code 14 is polarity 1 with ratio 8
        chk("R6 code 14 limit", lim_of(4'd14), BASE * 8);

        // R7: stop during a delay (single, code 1, limit 16)
        do_reset(1'b0, 4'd1);
        @(negedge clk);
        din = 1'b1; n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            n++;
            if (n == 5)  osc_en = 1'b0;
            if (n == 25) osc_en = 1'b1;
            if (dout) break;
        end
        chk("R7 stop mid delay", n, LAT + 16 + 20);
        // R7: start while stopped
        measure(1'b0, 1'b0, n);
        repeat (2) @(negedge clk);
        osc_en = 1'b0;
        din = 1'b1; n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            n++;
            if (n == 10) osc_en = 1'b1;
            if (dout) break;
        end
        chk("R7 start while stopped", n, LAT + 16 + 7);

        // R8: single-edge cancel, then a full restart
        do_reset(1'b0, 4'd1);
        pulse(6, 60, 1'b0, f, w);
        chk("R8 cancelled width", w, 0);
        measure(1'b1, 1'b1, n);
        chk("R8 full delay after cancel", n, LAT + 16);
        measure(1'b0, 1'b0, n);
        // R2: long pulse in single mode shortened by the delay
        pulse(20, 60, 1'b0, f, w);
        chk("R2 long pulse first", f, LAT + 16);
        chk("R2 long pulse width", w, 4);

        // R9: suppression boundary, limit 2 and limit 16
        do_reset(1'b1, 4'd0);
        pulse(2, 20, 1'b0, f, w);
        chk("R9 pulse equal limit 2", w, 0);
        pulse(3, 20, 1'b0, f, w);
        chk("R9 pulse limit+1 first", f, LAT + 2);
        chk("R9 pulse limit+1 width", w, 3);
        do_reset(1'b1, 4'd1);
        pulse(16, 60, 1'b0, f, w);
        chk("R9 pulse equal limit 16", w, 0);
        pulse(17, 60, 1'b0, f, w);
        chk("R9 pulse 17 first", f, LAT + 16);
        chk("R9 pulse 17 width", w, 17);

        // R10: code change during a pending delay
        do_reset(1'b0, 4'd1);
        @(negedge clk);
        din = 1'b1; n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            n++;
            if (n == 5) begin div_code = 4'd0; both_mode = 1'b1; end
            if (dout) break;
        end
        chk("R10 delay kept", n, LAT + 16);
        repeat (3) @(negedge clk);
        measure(1'b0, 1'b0, n);
        chk("R10 new config applied", n, LAT + 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule